// File: doc/BRIEF.md
# Interleaved DRAM Slot Sequencer

This block shares a nibble-wide page-mode DRAM between a video fetcher and a CPU. It runs from a 16 MHz clock and cuts time into 500 ns slots of eight phases. In each slot it either stays idle or runs one complete byte access: a single row-strobe cycle containing two column-strobe pulses. Each pulse moves one 4-bit half of the byte. Reads come back as an assembled byte. Writes send the low half first and then the high half.

At the start of each slot the block decides who owns it. It looks at the display-active flag, the mode class (80 or 40 bytes per line) and an enhancement enable that lets the CPU use slots that would otherwise go unused. It also produces a CPU clock enable. A CPU cycle to the upper half of the address space (bit 15 set) never touches the DRAM and completes in every slot. A lower-half cycle completes only in a slot the CPU owns, so the CPU runs at 2 MHz, at 1 MHz, or stalls, depending on who owns the slots.

Top module: `dram_slot_seq`

## Requirements
- R1: While reset is high, ram_ras_n, ram_cas_n and ram_we_n are high, ram_dq_oe, cpu_ce and vid_valid are low. Phase counting restarts so that the first clock cycle after reset release is phase 0 of slot 0, and slot k spans cycles 8k to 8k+7.
- R2: In a slot that accesses the DRAM, ram_ras_n is low during phases 1 to 6 and high during phases 7 and 0. In any other slot it stays high throughout.
- R3: ram_cas_n is low during phases 3, 4 and 6 of an accessing slot and high otherwise. ram_a carries address bits 14:7 in phase 1, then {bits 6:0, 0} in phases 2 to 4, then {bits 6:0, 1} in phases 5 to 7.
- R4: A read byte is {nibble sampled at the end of phase 6, nibble sampled at the end of phase 4}. In phase 7 it appears on vid_data with vid_valid high for a video slot, or on cpu_rdata with cpu_ce high for a CPU slot. vid_valid is high only in phase 7 of a video slot.
- R5: All inputs (mode class, display flag, enhancement enable, both addresses, write flag and write data) are sampled at the end of phase 0. Changes later in the slot do not affect that slot.
- R6: With the display active and mode_wide high, every slot is a video slot, and a CPU cycle with address bit 15 low gets no cpu_ce.
- R7: With the display active and mode_wide low, even-numbered slots are video slots and odd-numbered slots are CPU slots.
- R8: With the display inactive and enh_en low, odd slots go to the CPU and even slots are idle (no strobes, no enable). With enh_en high, every slot goes to the CPU.
- R9: When cpu_addr[15] is high, cpu_ce is high in phase 7 of every slot and no DRAM cycle is made for that CPU access (a write there changes no memory). cpu_ce is never high outside phase 7.
- R10: When cpu_addr[15] is low and the slot is not a CPU slot, cpu_ce stays low for the whole slot.
- R11: In a CPU write slot, ram_we_n is low and ram_dq_oe high during phases 2 to 6. ram_dq_o holds write bits 3:0 in phases 2 to 4 and bits 7:4 in phases 5 and 6. Reads keep ram_we_n high and ram_dq_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz phase clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | 1 = 80-byte-per-line class, 0 = 40-byte class |
| disp_active | input | 1 | Display fetch window is open |
| enh_en | input | 1 | Give the CPU every slot outside the display window |
| vid_addr | input | 15 | Video fetch byte address |
| vid_data | output | 8 | Byte fetched for video |
| vid_valid | output | 1 | vid_data valid, advance fetch address |
| cpu_addr | input | 16 | CPU address; bit 15 selects the upper region |
| cpu_wr | input | 1 | CPU cycle is a write |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte read for the CPU |
| cpu_ce | output | 1 | CPU clock enable, one pulse per completed cycle |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_a | output | 8 | Multiplexed row/column address |
| ram_dq_o | output | 4 | Write nibble |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_o |
| ram_dq_i | input | 4 | Read nibble |

## Verification
The embedded properties check the strobe envelope on every cycle: the row strobe falls only in phase 1, the column strobe is low only inside the row strobe, the column address stays still across a strobe pulse, write enable never comes without drive, the enable appears only in the last phase, and a high-region cycle is never stalled. Who owns each slot under each mode, the byte values assembled from the two halves, data written through two column pulses and read back later, and the fact that inputs changed mid-slot have no effect can only be shown by the bench's scenarios. The bench does this with a nibble memory model and a scoreboard of expected slots.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_VID  = 2'd1,
    OWN_CPU  = 2'd2
  } own_e;

  // Slot attributes frozen at the end of phase 0
  typedef struct packed {
    own_e own;   // who holds the slot
    logic hi;    // CPU cycle targets the upper region
    logic acc;   // a DRAM cycle runs in this slot
    logic act;   // display window was open
    logic wide;  // 80-byte line class
    logic wr;    // DRAM cycle is a CPU write
  } slot_t;

  localparam slot_t SLOT_IDLE = '{own: OWN_IDLE, hi: 1'b0, acc: 1'b0,
                                  act: 1'b0, wide: 1'b0, wr: 1'b0};

endpackage

// File: rtl/dss_phase.sv
module dss_phase #(
  parameter  int NPH = 8,
  localparam int PHW = $clog2(NPH)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [PHW-1:0] ph,
  output logic [PHW-1:0] ph_nx,
  output logic           go,
  output logic           par
);

  localparam logic [PHW-1:0] PH_LAST = PHW'(NPH - 1);

  always_comb begin
    ph_nx = (ph == PH_LAST) ? '0 : ph + 1'b1;
    go    = (ph == '0);
  end

  // par is the parity of the slot now in phase 0
  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      par <= 1'b0;
    end else begin
      ph <= ph_nx;
      if (go) par <= ~par;
    end
  end

  a_r2_slot_wraps: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LAST) |=> (ph == '0));

  a_r7_parity_alternates: assert property (@(posedge clk) disable iff (rst)
    go |=> (par != $past(par)));

endmodule

// File: rtl/dss_owner.sv
module dss_owner
  import dss_pkg::*;
(
  input  logic act,
  input  logic wide,
  input  logic enh,
  input  logic par,
  output own_e own
);

  always_comb begin
    if (act) begin
      own = (wide || !par) ? OWN_VID : OWN_CPU;
    end else if (enh || par) begin
      own = OWN_CPU;
    end else begin
      own = OWN_IDLE;
    end
  end

endmodule

// File: rtl/dss_dram_if.sv
module dss_dram_if #(
  parameter  int NW    = 4,
  parameter  int AW    = 15,
  parameter  int NPH   = 8,
  parameter  int P_RAS = 1,
  parameter  int P_WE  = 2,
  parameter  int P_C0  = 3,
  parameter  int P_C0E = 4,
  parameter  int P_C1A = 5,
  parameter  int P_C1  = 6,
  localparam int PHW   = $clog2(NPH),
  localparam int BW    = 2 * NW,
  localparam int RW    = (AW + 1) / 2,
  localparam int COLB  = RW - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PHW-1:0] ph,
  input  logic [PHW-1:0] ph_nx,
  input  logic           acc,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [BW-1:0]  wdat,
  input  logic [NW-1:0]  dq_i,
  output logic           ras_n,
  output logic           cas_n,
  output logic           we_n,
  output logic [RW-1:0]  a,
  output logic [NW-1:0]  dq_o,
  output logic           dq_oe,
  output logic [BW-1:0]  rbyte
);

  logic [RW-1:0] row, col0, col1;
  logic          in_ras, in_cas, in_wr;
  logic [NW-1:0] nib0;

  always_comb begin
    row    = addr[AW-1:COLB];
    col0   = {addr[COLB-1:0], 1'b0};
    col1   = {addr[COLB-1:0], 1'b1};
    in_ras = acc && (ph_nx >= PHW'(P_RAS)) && (ph_nx <= PHW'(P_C1));
    in_cas = acc && ((ph_nx == PHW'(P_C0)) || (ph_nx == PHW'(P_C0E)) ||
                     (ph_nx == PHW'(P_C1)));
    in_wr  = acc && wr && (ph_nx >= PHW'(P_WE)) && (ph_nx <= PHW'(P_C1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      a     <= '0;
      dq_o  <= '0;
      nib0  <= '0;
      rbyte <= '0;
    end else begin
      ras_n <= ~in_ras;
      cas_n <= ~in_cas;
      we_n  <= ~in_wr;
      dq_oe <= in_wr;
      if (ph_nx <= PHW'(P_RAS))     a <= row;
      else if (ph_nx < PHW'(P_C1A)) a <= col0;
      else                          a <= col1;
      dq_o <= (ph_nx < PHW'(P_C1A)) ? wdat[NW-1:0] : wdat[BW-1:NW];
      if (ph == PHW'(P_C0E)) nib0  <= dq_i;
      if (ph == PHW'(P_C1))  rbyte <= {dq_i, nib0};
    end
  end

  a_r2_ras_falls_in_phase1: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (ph == PHW'(P_RAS)));

  a_r2_ras_high_in_phase0: assert property (@(posedge clk) disable iff (rst)
    (ph == '0) |-> ras_n);

  a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  a_r3_column_steady: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && $past(!cas_n)) |-> $stable(a));

  a_r11_we_with_drive: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> dq_oe);

endmodule

// File: rtl/dss_cpu_gate.sv
module dss_cpu_gate
  import dss_pkg::*;
#(
  parameter  int NPH   = 8,
  localparam int PHW   = $clog2(NPH),
  localparam int P_END = NPH - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PHW-1:0] ph,
  input  logic [PHW-1:0] ph_nx,
  input  logic           hi,
  input  own_e           own,
  output logic           cpu_ce,
  output logic           vid_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ce    <= 1'b0;
      vid_valid <= 1'b0;
    end else begin
      cpu_ce    <= (ph_nx == PHW'(P_END)) && (hi || (own == OWN_CPU));
      vid_valid <= (ph_nx == PHW'(P_END)) && (own == OWN_VID);
    end
  end

  a_r9_ce_last_phase_only: assert property (@(posedge clk) disable iff (rst)
    cpu_ce |-> (ph == PHW'(P_END)));

  a_r4_valid_last_phase_only: assert property (@(posedge clk) disable iff (rst)
    vid_valid |-> (ph == PHW'(P_END)));

endmodule

// File: rtl/dram_slot_seq.sv
module dram_slot_seq
  import dss_pkg::*;
#(
  parameter  int NW  = 4,
  parameter  int AW  = 15,
  parameter  int NPH = 8,
  localparam int BW  = 2 * NW,
  localparam int RW  = (AW + 1) / 2,
  localparam int PHW = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wide,
  input  logic          disp_active,
  input  logic          enh_en,
  input  logic [AW-1:0] vid_addr,
  output logic [BW-1:0] vid_data,
  output logic          vid_valid,
  input  logic [AW:0]   cpu_addr,
  input  logic          cpu_wr,
  input  logic [BW-1:0] cpu_wdata,
  output logic [BW-1:0] cpu_rdata,
  output logic          cpu_ce,
  output logic          ram_ras_n,
  output logic          ram_cas_n,
  output logic          ram_we_n,
  output logic [RW-1:0] ram_a,
  output logic [NW-1:0] ram_dq_o,
  output logic          ram_dq_oe,
  input  logic [NW-1:0] ram_dq_i
);

  localparam logic [PHW-1:0] PH_END = PHW'(NPH - 1);

  logic [PHW-1:0] ph, ph_nx;
  logic           go, par;
  own_e           own_new;
  slot_t          sl_new, sl_q, sl_d;
  logic [AW-1:0]  addr_new, addr_q, addr_d;
  logic [BW-1:0]  wdat_q, wdat_d;
  logic [BW-1:0]  rbyte;

  dss_phase #(.NPH(NPH)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .ph    (ph),
    .ph_nx (ph_nx),
    .go    (go),
    .par   (par)
  );

  dss_owner u_owner (
    .act  (disp_active),
    .wide (mode_wide),
    .enh  (enh_en),
    .par  (par),
    .own  (own_new)
  );

  always_comb begin
    sl_new.own  = own_new;
    sl_new.hi   = cpu_addr[AW];
    sl_new.acc  = (own_new == OWN_VID) || ((own_new == OWN_CPU) && !cpu_addr[AW]);
    sl_new.act  = disp_active;
    sl_new.wide = mode_wide;
    sl_new.wr   = (own_new == OWN_CPU) && !cpu_addr[AW] && cpu_wr;
    addr_new    = (own_new == OWN_CPU) ? cpu_addr[AW-1:0] : vid_addr;
    sl_d        = go ? sl_new    : sl_q;
    addr_d      = go ? addr_new  : addr_q;
    wdat_d      = go ? cpu_wdata : wdat_q;
  end

  // Slot attributes frozen at the end of phase 0
  always_ff @(posedge clk) begin
    if (rst) begin
      sl_q   <= SLOT_IDLE;
      addr_q <= '0;
      wdat_q <= '0;
    end else if (go) begin
      sl_q   <= sl_new;
      addr_q <= addr_new;
      wdat_q <= cpu_wdata;
    end
  end

  dss_dram_if #(.NW(NW), .AW(AW), .NPH(NPH)) u_dram (
    .clk   (clk),
    .rst   (rst),
    .ph    (ph),
    .ph_nx (ph_nx),
    .acc   (sl_d.acc),
    .wr    (sl_d.wr),
    .addr  (addr_d),
    .wdat  (wdat_d),
    .dq_i  (ram_dq_i),
    .ras_n (ram_ras_n),
    .cas_n (ram_cas_n),
    .we_n  (ram_we_n),
    .a     (ram_a),
    .dq_o  (ram_dq_o),
    .dq_oe (ram_dq_oe),
    .rbyte (rbyte)
  );

  dss_cpu_gate #(.NPH(NPH)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .ph        (ph),
    .ph_nx     (ph_nx),
    .hi        (sl_d.hi),
    .own       (sl_d.own),
    .cpu_ce    (cpu_ce),
    .vid_valid (vid_valid)
  );

  assign vid_data  = rbyte;
  assign cpu_rdata = rbyte;

  a_r5_slot_held: assert property (@(posedge clk) disable iff (rst)
    !go |=> ($stable(sl_q) && $stable(addr_q) && $stable(wdat_q)));

  a_r6_wide_blocks_low_cpu: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_END) && sl_q.act && sl_q.wide && !sl_q.hi) |-> !cpu_ce);

  a_r9_high_never_stalls: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_END) && sl_q.hi) |-> cpu_ce);

  a_r8_idle_slot_quiet: assert property (@(posedge clk) disable iff (rst)
    (sl_q.own == OWN_IDLE) |-> (ram_ras_n && ram_cas_n && ram_we_n));

endmodule

// File: tb/test_dram_slot_seq.sv
`timescale 1ns/1ps
module test_dram_slot_seq;

  localparam int NW = 4;
  localparam int AW = 15;
  localparam int BW = 8;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_wide = 1'b0, disp_active = 1'b0, enh_en = 1'b0;
  logic [AW-1:0] vid_addr = '0;
  logic [AW:0]   cpu_addr = '0;
  logic          cpu_wr = 1'b0;
  logic [BW-1:0] cpu_wdata = '0;
  logic [BW-1:0] vid_data, cpu_rdata;
  logic          vid_valid, cpu_ce;
  logic          ram_ras_n, ram_cas_n, ram_we_n, ram_dq_oe;
  logic [RW-1:0] ram_a;
  logic [NW-1:0] ram_dq_o;
  logic [NW-1:0] ram_dq_i = '0;

  always #4 clk = ~clk;

  dram_slot_seq i_dram_slot_seq (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .disp_active(disp_active),
    .enh_en(enh_en), .vid_addr(vid_addr), .vid_data(vid_data),
    .vid_valid(vid_valid), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ce(cpu_ce),
    .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n), .ram_we_n(ram_we_n),
    .ram_a(ram_a), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe),
    .ram_dq_i(ram_dq_i)
  );

  int total = 0, bad = 0;
  int ph_b = 0, sk = 0;
  bit done = 1'b0;

  typedef struct {
    bit          ram;
    bit          wr;
    bit [AW-1:0] a;
    bit [BW-1:0] wd;
    bit          ce;
    bit          vv;
    bit [BW-1:0] dat;
    bit          chk_v;
    bit          chk_c;
    string       tce;
    string       tvv;
  } exp_t;

  exp_t        sbq[$];
  bit [BW-1:0] shadow[int];
  bit [NW-1:0] mem_n[int];
  bit [RW-1:0] row_lat = '0;
  logic        ras_prev = 1'b1;
  int          mkey;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [NW-1:0] dnib(bit [RW-1:0] r, bit [RW-1:0] c);
    bit [RW-1:0] m;
    m = r ^ (r >> 4) ^ c ^ (c >> 3) ^ 8'h5a;
    return m[NW-1:0];
  endfunction

  function automatic bit [BW-1:0] get_byte(bit [AW-1:0] a);
    if (shadow.exists(int'(a))) return shadow[int'(a)];
    return {dnib(a[14:7], {a[6:0], 1'b1}), dnib(a[14:7], {a[6:0], 1'b0})};
  endfunction

  // bench phase and slot count (R1: slot k spans cycles 8k..8k+7 after release)
  always @(posedge clk) begin
    if (rst) begin
      ph_b <= 0;
      sk   <= 0;
    end else begin
      ph_b <= (ph_b == 7) ? 0 : ph_b + 1;
      if (ph_b == 7) sk <= sk + 1;
    end
  end

  // nibble-wide DRAM model
  always @(negedge clk) begin
    if (ram_ras_n === 1'b0 && ras_prev === 1'b1) row_lat = ram_a;
    ras_prev = ram_ras_n;
    mkey = int'({row_lat, ram_a});
    if (ram_cas_n === 1'b0 && ram_we_n === 1'b0) mem_n[mkey] = ram_dq_o;
    ram_dq_i <= mem_n.exists(mkey) ? mem_n[mkey] : dnib(row_lat, ram_a);
  end

  // monitor: pops the scoreboard in phase 7
  always @(negedge clk) begin
    exp_t e;
    bit [RW-1:0] a_e;
    if (!rst && !done) begin
      e.ram = 0; e.wr = 0; e.a = '0; e.wd = '0; e.ce = 0; e.vv = 0;
      e.dat = '0; e.chk_v = 0; e.chk_c = 0; e.tce = "R8"; e.tvv = "R8";
      if (sbq.size() > 0 && ph_b != 0) e = sbq[0];
      chk("R2", "ras_n", int'(ram_ras_n), int'(!(e.ram && ph_b >= 1 && ph_b <= 6)));
      chk("R3", "cas_n", int'(ram_cas_n),
          int'(!(e.ram && (ph_b == 3 || ph_b == 4 || ph_b == 6))));
      if (e.ram && ph_b >= 1) begin
        if (ph_b == 1)      a_e = e.a[14:7];
        else if (ph_b <= 4) a_e = {e.a[6:0], 1'b0};
        else                a_e = {e.a[6:0], 1'b1};
        chk("R3", "ram_a", int'(ram_a), int'(a_e));
      end
      chk("R11", "we_n", int'(ram_we_n), int'(!(e.wr && ph_b >= 2 && ph_b <= 6)));
      chk("R11", "dq_oe", int'(ram_dq_oe), int'(e.wr && ph_b >= 2 && ph_b <= 6));
      if (e.wr && ph_b >= 2 && ph_b <= 6)
        chk("R11", "dq_o", int'(ram_dq_o),
            int'((ph_b <= 4) ? e.wd[3:0] : e.wd[7:4]));
      if (ph_b == 7) begin
        chk(e.tce, "cpu_ce", int'(cpu_ce), int'(e.ce));
        chk(e.tvv, "vid_valid", int'(vid_valid), int'(e.vv));
        if (e.chk_v) chk("R4", "vid_data", int'(vid_data), int'(e.dat));
        if (e.chk_c) chk("R4", "cpu_rdata", int'(cpu_rdata), int'(e.dat));
        if (sbq.size() > 0) void'(sbq.pop_front());
      end else begin
        chk("R9", "cpu_ce off phase 7", int'(cpu_ce), 0);
        chk("R4", "vid_valid off phase 7", int'(vid_valid), 0);
      end
    end
  end

  // driver: sets one slot's inputs in phase 0 and pushes its expectation
  task automatic run_slot(bit act, bit wide, bit enh, bit [AW:0] ca, bit cw,
                          bit [BW-1:0] wd, bit [AW-1:0] va, bit scr);
    exp_t e;
    int   own;  // 0 idle, 1 video, 2 cpu
    bit   hi;
    @(negedge clk);
    while (ph_b != 0) @(negedge clk);
    disp_active = act; mode_wide = wide; enh_en = enh;
    cpu_addr = ca; cpu_wr = cw; cpu_wdata = wd; vid_addr = va;
    if (act)                   own = (wide || (sk % 2 == 0)) ? 1 : 2;
    else if (enh || sk % 2)    own = 2;
    else                       own = 0;
    hi      = ca[AW];
    e.ram   = (own == 1) || (own == 2 && !hi);
    e.a     = (own == 2) ? ca[AW-1:0] : va;
    e.wr    = (own == 2) && !hi && cw;
    e.wd    = wd;
    e.ce    = hi || (own == 2);
    e.vv    = (own == 1);
    e.dat   = get_byte(e.a);
    e.chk_v = (own == 1);
    e.chk_c = (own == 2) && !hi && !cw;
    if (e.wr) shadow[int'(e.a)] = wd;
    if (scr)            e.tce = "R5";
    else if (hi)        e.tce = "R9";
    else if (own == 2)  e.tce = act ? "R7" : "R8";
    else if (own == 1)  e.tce = wide ? "R6" : "R10";
    else                e.tce = "R10";
    if (scr)      e.tvv = "R5";
    else if (act) e.tvv = wide ? "R6" : "R7";
    else          e.tvv = "R8";
    sbq.push_back(e);
    if (scr) begin
      @(negedge clk);
      @(negedge clk);
      disp_active = ~act; mode_wide = ~wide; enh_en = ~enh;
      cpu_addr = ~ca; cpu_wr = ~cw; cpu_wdata = ~wd; vid_addr = ~va;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "ras_n", int'(ram_ras_n), 1);
    chk("R1", "cas_n", int'(ram_cas_n), 1);
    chk("R1", "we_n", int'(ram_we_n), 1);
    chk("R1", "dq_oe", int'(ram_dq_oe), 0);
    chk("R1", "cpu_ce", int'(cpu_ce), 0);
    chk("R1", "vid_valid", int'(vid_valid), 0);
    rst = 1'b0;

    // R8 default: CPU only on odd slots, R10 stall on idle ones
    for (int i = 0; i < 4; i++)
      run_slot(0, 0, 0, 16'h0123, 0, 8'h00, 15'h0000, 0);
    // R8 enhanced: CPU every slot, R11 writes
    for (int i = 0; i < 4; i++)
      run_slot(0, 0, 1, 16'h0100 + 16'(i), 1, 8'hA3 + 8'(i * 17), 15'h0000, 0);
    // R4 read back through the CPU
    for (int i = 0; i < 4; i++)
      run_slot(0, 0, 1, 16'h0100 + 16'(i), 0, 8'h00, 15'h0000, 0);
    // R7 narrow display: alternating video and CPU
    for (int i = 0; i < 4; i++)
      run_slot(1, 0, 0, 16'h0102, 0, 8'h00, 15'h0100 + 15'(i), 0);
    // R6 wide display: CPU low region stalls
    for (int i = 0; i < 4; i++)
      run_slot(1, 1, 1, 16'h0101, 0, 8'h00, 15'h7F80 + 15'(i), 0);
    // R9 upper region: runs every slot, a write there changes nothing
    for (int i = 0; i < 4; i++)
      run_slot(1, 1, 0, 16'h8000 + 16'(i), 1, 8'h55, 15'h0103, 0);
    for (int i = 0; i < 3; i++)
      run_slot(0, 0, 0, 16'hC123, 0, 8'h00, 15'h0000, 0);
    for (int i = 0; i < 4; i++)
      run_slot(0, 0, 1, 16'h0000 + 16'(i), 0, 8'h00, 15'h0000, 0);
    // R5 inputs flipped mid-slot
    run_slot(0, 0, 1, 16'h2345, 1, 8'h3C, 15'h0000, 1);
    run_slot(1, 0, 0, 16'h0456, 0, 8'h00, 15'h2345, 1);
    run_slot(1, 0, 0, 16'h2345, 0, 8'h00, 15'h1111, 1);
    run_slot(1, 1, 0, 16'h2345, 0, 8'h00, 15'h2345, 1);
    run_slot(0, 0, 1, 16'h2345, 0, 8'h00, 15'h0000, 0);
    run_slot(0, 0, 0, 16'h0000, 0, 8'h00, 15'h0000, 0);
    repeat (10) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule